// File: doc/BRIEF.md
# Pointer-Capable Working Register File

This block is the working register store of a small 8-bit RISC core. It holds thirty-two byte-wide registers, offers two independent byte read ports and one 16-bit pair read port, and accepts one write per cycle of either a single byte or a full even/odd register pair. All reads are combinational and return the contents as they stood before the clock edge that commits any write in the same cycle.

The six highest registers pair up into three 16-bit address pointers (selector 0, 1 and 2, lower-numbered register holding the low byte). An address-generation path picks one pointer and produces a data address in one of four modes: plain, post-increment, pre-decrement or displacement. The two modes that change the pointer write the updated value back at the next clock edge. A byte-addressed data-space port maps the whole file onto addresses 0x00 to 0x1F, so that loads and stores (including ones whose address came from a pointer) can reach the registers themselves.

Every port completes in the cycle it is presented: the file never stalls, so no request waits and no back-pressure signal exists. When several writers touch the same register in one cycle, a fixed priority decides which byte lands.

Top module: `ptr_regfile`

## Requirements
- R1: After reset every register reads 0x00.
- R2: With wr_en=1 and wr_wide=0, wr_data[7:0] is stored into register wr_idx at the clock edge; a read of that register in the same cycle returns the old value.
- R3: The two byte read ports are independent and combinational: rd_a_data shows register rd_a_idx and rd_b_data shows register rd_b_idx in the same cycle.
- R4: With wr_en=1 and wr_wide=1, wr_idx[0] is ignored; wr_data[7:0] goes to register {wr_idx[4:1],0} and wr_data[15:8] to register {wr_idx[4:1],1} in the same edge.
- R5: rd_w_data equals {register {rd_w_idx[4:1],1}, register {rd_w_idx[4:1],0}}, with rd_w_idx[0] ignored.
- R6: ag_sel 0 selects the pointer {R27,R26}, 1 selects {R29,R28}, and both 2 and 3 select {R31,R30}; ag_addr reflects the selected pointer in the same cycle.
- R7: ag_mode 0 (plain): ag_addr is the pointer, and the pointer is not changed.
- R8: ag_mode 1 (post-increment): ag_addr is the old pointer; when ag_en=1 the pointer becomes old+1 modulo 2^16 at the clock edge.
- R9: ag_mode 2 (pre-decrement): ag_addr is old-1 modulo 2^16; when ag_en=1 that value is written back to the pointer at the clock edge.
- R10: ag_mode 3 (displacement): for selectors 1 to 3, ag_addr is the pointer plus ag_disp zero-extended (0 to 63); for selector 0 the offset is ignored and ag_addr is the pointer; the pointer is never changed.
- R11: ds_hit is 1 exactly when ds_addr is below 0x20; then ds_rdata shows register ds_addr and a write (ds_en=1, ds_we=1) stores ds_wdata there; otherwise ds_rdata is 0x00 and the write changes no register.
- R12: When writers meet on one register in the same cycle, the explicit write port wins over the data-space port, which wins over the pointer write-back; bytes of a pair not claimed by a higher writer still take the lower writer's value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Byte read port A index |
| rd_a_data | output | 8 | Byte read port A data |
| rd_b_idx | input | 5 | Byte read port B index |
| rd_b_data | output | 8 | Byte read port B data |
| rd_w_idx | input | 5 | Pair read index (bit 0 ignored) |
| rd_w_data | output | 16 | Pair read data, high byte from odd register |
| wr_en | input | 1 | Explicit write enable |
| wr_wide | input | 1 | 1 = pair write, 0 = byte write |
| wr_idx | input | 5 | Explicit write index |
| wr_data | input | 16 | Explicit write data (low byte only for byte writes) |
| ag_en | input | 1 | Address generation active; enables pointer write-back |
| ag_sel | input | 2 | Pointer selector |
| ag_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| ag_disp | input | 6 | Unsigned displacement |
| ag_addr | output | 16 | Generated data address |
| ds_en | input | 1 | Data-space access enable |
| ds_we | input | 1 | Data-space write strobe |
| ds_addr | input | 16 | Data-space byte address |
| ds_wdata | input | 8 | Data-space write data |
| ds_hit | output | 1 | Address falls inside the register window |
| ds_rdata | output | 8 | Data-space read data |

## Verification
The hardest case to reach is a single cycle in which the explicit port, the data-space port and a pointer write-back all aim at the same pointer byte, since three independent inputs must line up on the same six registers. The random stimulus draws indices and data-space addresses with a strong bias toward registers 26 to 31, and directed steps force the three-way and two-way collisions, including a pointer update whose high byte survives while its low byte is overridden. Directed steps also drive the pointer wrap at 0xFFFF and 0x0000 and the largest displacement with a carry into the high byte.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;

  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_POSTINC = 2'd1,
    AM_PREDEC  = 2'd2,
    AM_DISP    = 2'd3
  } am_e;

  typedef enum logic [1:0] {
    PS_X    = 2'd0,
    PS_Y    = 2'd1,
    PS_Z    = 2'd2,
    PS_ZALT = 2'd3
  } ps_e;

  // Map a selector onto one of the three pointer slots.
  function automatic logic [1:0] ps_slot(input ps_e s);
    return (s == PS_ZALT) ? 2'd2 : 2'(s);
  endfunction

endpackage

// File: rtl/rf_store.sv
`timescale 1ns/1ps
module rf_store #(
  parameter int NREG = 32,
  parameter int W    = 8,
  parameter int IW   = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  // explicit result writer (highest priority)
  input  logic                   e_en,
  input  logic                   e_wide,
  input  logic [IW-1:0]          e_idx,
  input  logic [2*W-1:0]         e_data,
  // data-space writer
  input  logic                   d_en,
  input  logic [IW-1:0]          d_idx,
  input  logic [W-1:0]           d_data,
  // pointer write-back (lowest priority)
  input  logic                   p_en,
  input  logic [IW-1:0]          p_idx,
  input  logic [2*W-1:0]         p_data,
  output logic [NREG-1:0][W-1:0] regs_q
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [IW-1:0] GI = IW'(g);
    logic         e_hit, d_hit, p_hit;
    logic [W-1:0] nxt, q;

    always_comb begin
      e_hit = e_en && (e_wide ? (e_idx[IW-1:1] == GI[IW-1:1]) : (e_idx == GI));
      d_hit = d_en && (d_idx == GI);
      p_hit = p_en && (p_idx[IW-1:1] == GI[IW-1:1]);
      nxt   = q;
      if (e_hit)      nxt = (e_wide && GI[0]) ? e_data[2*W-1:W] : e_data[W-1:0];
      else if (d_hit) nxt = d_data;
      else if (p_hit) nxt = GI[0] ? p_data[2*W-1:W] : p_data[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
    end

    assign regs_q[g] = q;
  end

  // R2: a byte write always lands, whoever else writes
  p_byte_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (e_en && !e_wide) |=> regs_q[$past(e_idx)] == $past(e_data[W-1:0]));

  // R4: a pair write lands on both halves, low index bit ignored
  p_wide_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (e_en && e_wide) |=> regs_q[{$past(e_idx[IW-1:1]), 1'b0}] == $past(e_data[W-1:0]));

  p_wide_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (e_en && e_wide) |=> regs_q[{$past(e_idx[IW-1:1]), 1'b1}] == $past(e_data[2*W-1:W]));

  // R12: data-space write beats pointer write-back when the explicit port is idle
  p_ds_over_ptr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (d_en && !e_en) |=> regs_q[$past(d_idx)] == $past(d_data));

endmodule

// File: rtl/rf_agu.sv
`timescale 1ns/1ps
module rf_agu
  import rf_pkg::*;
#(
  parameter int PW    = 16,
  parameter int DISPW = 6
) (
  input  logic             en,
  input  am_e              mode,
  input  logic             use_disp,
  input  logic [DISPW-1:0] disp,
  input  logic [PW-1:0]    ptr,
  output logic [PW-1:0]    addr,
  output logic             wb_en,
  output logic [PW-1:0]    wb_val
);

  logic [PW-1:0] inc, dec, off;

  always_comb begin
    inc    = ptr + PW'(1);
    dec    = ptr - PW'(1);
    off    = use_disp ? PW'(disp) : '0;
    addr   = ptr;
    wb_en  = 1'b0;
    wb_val = ptr;
    unique case (mode)
      AM_PLAIN: begin
        addr = ptr;
      end
      AM_POSTINC: begin
        addr   = ptr;
        wb_en  = en;
        wb_val = inc;
      end
      AM_PREDEC: begin
        addr   = dec;
        wb_en  = en;
        wb_val = dec;
      end
      AM_DISP: begin
        addr = ptr + off;
      end
      default: addr = ptr;
    endcase
  end

endmodule

// File: rtl/rf_dspace.sv
`timescale 1ns/1ps
module rf_dspace #(
  parameter int NREG = 32,
  parameter int W    = 8,
  parameter int AW   = 16,
  parameter int IW   = $clog2(NREG)
) (
  input  logic                   en,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [W-1:0]           wdata,
  input  logic [NREG-1:0][W-1:0] regs,
  output logic                   hit,
  output logic [W-1:0]           rdata,
  output logic                   wr_en,
  output logic [IW-1:0]          wr_idx,
  output logic [W-1:0]           wr_data
);

  localparam logic [AW-1:0] LIMIT = AW'(NREG);

  always_comb begin
    hit     = (addr < LIMIT);
    wr_idx  = addr[IW-1:0];
    rdata   = hit ? regs[wr_idx] : '0;
    wr_en   = en && we && hit;
    wr_data = wdata;
  end

endmodule

// File: rtl/ptr_regfile.sv
`timescale 1ns/1ps
module ptr_regfile
  import rf_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int W     = 8,
  parameter int DISPW = 6,
  parameter int IW    = $clog2(NREG),
  parameter int PW    = 2 * W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    rd_a_idx,
  output logic [W-1:0]     rd_a_data,
  input  logic [IW-1:0]    rd_b_idx,
  output logic [W-1:0]     rd_b_data,
  input  logic [IW-1:0]    rd_w_idx,
  output logic [PW-1:0]    rd_w_data,
  input  logic             wr_en,
  input  logic             wr_wide,
  input  logic [IW-1:0]    wr_idx,
  input  logic [PW-1:0]    wr_data,
  input  logic             ag_en,
  input  logic [1:0]       ag_sel,
  input  logic [1:0]       ag_mode,
  input  logic [DISPW-1:0] ag_disp,
  output logic [PW-1:0]    ag_addr,
  input  logic             ds_en,
  input  logic             ds_we,
  input  logic [PW-1:0]    ds_addr,
  input  logic [W-1:0]     ds_wdata,
  output logic             ds_hit,
  output logic [W-1:0]     ds_rdata
);

  localparam int NPTR  = 3;
  localparam int PBASE = NREG - 2 * NPTR;

  logic [NREG-1:0][W-1:0] regs_q;
  logic [NPTR-1:0][PW-1:0] ptrs;
  logic [1:0]              slot;
  logic [PW-1:0]           ptr_cur;
  logic                    wb_en;
  logic [PW-1:0]           wb_val;
  logic [IW-1:0]           p_idx;
  logic                    dsw_en;
  logic [IW-1:0]           dsw_idx;
  logic [W-1:0]            dsw_data;
  logic                    ds_wr_req;

  // pointer pairs, low byte in the even register
  for (genvar k = 0; k < NPTR; k++) begin : g_ptr
    assign ptrs[k] = {regs_q[PBASE + 2*k + 1], regs_q[PBASE + 2*k]};
  end

  always_comb begin
    slot    = ps_slot(ps_e'(ag_sel));
    ptr_cur = ptrs[slot];
    p_idx   = IW'(PBASE) + IW'({slot, 1'b0});
  end

  rf_agu #(.PW(PW), .DISPW(DISPW)) u_agu (
    .en       (ag_en),
    .mode     (am_e'(ag_mode)),
    .use_disp (slot != 2'd0),
    .disp     (ag_disp),
    .ptr      (ptr_cur),
    .addr     (ag_addr),
    .wb_en    (wb_en),
    .wb_val   (wb_val)
  );

  rf_dspace #(.NREG(NREG), .W(W), .AW(PW), .IW(IW)) u_dspace (
    .en      (ds_en),
    .we      (ds_we),
    .addr    (ds_addr),
    .wdata   (ds_wdata),
    .regs    (regs_q),
    .hit     (ds_hit),
    .rdata   (ds_rdata),
    .wr_en   (dsw_en),
    .wr_idx  (dsw_idx),
    .wr_data (dsw_data)
  );

  rf_store #(.NREG(NREG), .W(W), .IW(IW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .e_en   (wr_en),
    .e_wide (wr_wide),
    .e_idx  (wr_idx),
    .e_data (wr_data),
    .d_en   (dsw_en),
    .d_idx  (dsw_idx),
    .d_data (dsw_data),
    .p_en   (wb_en),
    .p_idx  (p_idx),
    .p_data (wb_val),
    .regs_q (regs_q)
  );

  // combinational read ports, pre-write values
  always_comb begin
    rd_a_data = regs_q[rd_a_idx];
    rd_b_data = regs_q[rd_b_idx];
    rd_w_data = {regs_q[{rd_w_idx[IW-1:1], 1'b1}], regs_q[{rd_w_idx[IW-1:1], 1'b0}]};
  end

  assign ds_wr_req = ds_en && ds_we;

  // R7: plain mode leaves every pointer alone when nobody else writes
  p_plain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ag_en && ag_mode == 2'd0 && !wr_en && !ds_wr_req) |=> $stable(ptrs));

  // R8: post-increment writes old address plus one
  p_postinc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ag_en && ag_mode == 2'd1 && !wr_en && !ds_wr_req)
      |=> ptrs[$past(slot)] == PW'($past(ag_addr) + PW'(1)));

  // R9: pre-decrement stores the very address it produced
  p_predec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ag_en && ag_mode == 2'd2 && !wr_en && !ds_wr_req)
      |=> ptrs[$past(slot)] == $past(ag_addr));

  // R10: displacement never modifies a pointer
  p_disp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ag_en && ag_mode == 2'd3 && !wr_en && !ds_wr_req) |=> $stable(ptrs));

  // R11: a data-space write outside the window touches nothing
  p_ds_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_wr_req && !ds_hit && !wr_en && !ag_en) |=> $stable(regs_q));

  // R11: outside the window the read data is zero
  p_ds_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_hit |-> ds_rdata == '0);

endmodule

// File: tb/ptr_regfile_bench.sv
`timescale 1ns/1ps
module ptr_regfile_bench;

  localparam int NREG = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_idx, rd_b_idx, rd_w_idx, wr_idx;
  logic [7:0]  rd_a_data, rd_b_data, ds_wdata, ds_rdata;
  logic [15:0] rd_w_data, wr_data, ag_addr, ds_addr;
  logic        wr_en, wr_wide, ag_en, ds_en, ds_we, ds_hit;
  logic [1:0]  ag_sel, ag_mode;
  logic [5:0]  ag_disp;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] m [NREG];

  always #2 clk = ~clk;

  ptr_regfile u_ptr_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .rd_w_idx(rd_w_idx), .rd_w_data(rd_w_data),
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data),
    .ag_en(ag_en), .ag_sel(ag_sel), .ag_mode(ag_mode), .ag_disp(ag_disp),
    .ag_addr(ag_addr),
    .ds_en(ds_en), .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
    .ds_hit(ds_hit), .ds_rdata(ds_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ptr_base(input logic [1:0] s);
    return 26 + 2 * ((s == 2'd3) ? 2 : int'(s));
  endfunction

  function automatic logic [15:0] ptr_of(input logic [1:0] s);
    int b = ptr_base(s);
    return {m[b+1], m[b]};
  endfunction

  function automatic logic [15:0] exp_addr();
    logic [15:0] p = ptr_of(ag_sel);
    case (ag_mode)
      2'd0: return p;
      2'd1: return p;
      2'd2: return p - 16'd1;
      default: return (ag_sel == 2'd0) ? p : p + {10'd0, ag_disp};
    endcase
  endfunction

  task automatic idle();
    rd_a_idx = '0; rd_b_idx = '0; rd_w_idx = '0;
    wr_en = 0; wr_wide = 0; wr_idx = '0; wr_data = '0;
    ag_en = 0; ag_sel = '0; ag_mode = '0; ag_disp = '0;
    ds_en = 0; ds_we = 0; ds_addr = '0; ds_wdata = '0;
  endtask

  // inputs are set just after a falling edge; check, clock, update model
  task automatic step();
    logic [7:0]  nm [NREG];
    logic [15:0] p;
    int          b;
    string       mt [4] = '{"R7", "R8", "R9", "R10"};
    #1;
    chk("R3", rd_a_data, m[rd_a_idx]);
    chk("R3", rd_b_data, m[rd_b_idx]);
    chk("R5", rd_w_data, {m[{rd_w_idx[4:1], 1'b1}], m[{rd_w_idx[4:1], 1'b0}]});
    chk(mt[ag_mode], ag_addr, exp_addr());
    chk("R11", ds_hit, ds_addr < 16'd32);
    chk("R11", ds_rdata, (ds_addr < 16'd32) ? m[ds_addr[4:0]] : 8'h00);
    nm = m;
    if (ag_en && (ag_mode == 2'd1 || ag_mode == 2'd2)) begin
      b = ptr_base(ag_sel);
      p = (ag_mode == 2'd1) ? ptr_of(ag_sel) + 16'd1 : ptr_of(ag_sel) - 16'd1;
      nm[b] = p[7:0];
      nm[b+1] = p[15:8];
    end
    if (ds_en && ds_we && ds_addr < 16'd32) nm[ds_addr[4:0]] = ds_wdata;
    if (wr_en) begin
      if (wr_wide) begin
        nm[{wr_idx[4:1], 1'b0}] = wr_data[7:0];
        nm[{wr_idx[4:1], 1'b1}] = wr_data[15:8];
      end else begin
        nm[wr_idx] = wr_data[7:0];
      end
    end
    @(posedge clk);
    m = nm;
    @(negedge clk);
  endtask

  task automatic expect_reg(input string tag, input int idx, input logic [7:0] e);
    idle();
    rd_a_idx = 5'(idx);
    #1 chk(tag, rd_a_data, e);
    @(negedge clk);
  endtask

  task automatic expect_ag(input string tag, input logic [1:0] s, input logic [1:0] md,
                           input logic [5:0] d, input logic [15:0] e);
    idle();
    ag_sel = s; ag_mode = md; ag_disp = d;
    #1 chk(tag, ag_addr, e);
    @(negedge clk);
  endtask

  task automatic wr_b(input int idx, input logic [7:0] d);
    idle();
    wr_en = 1; wr_idx = 5'(idx); wr_data = {8'h00, d};
    step();
    idle();
  endtask

  task automatic wr_w(input int idx, input logic [15:0] d);
    idle();
    wr_en = 1; wr_wide = 1; wr_idx = 5'(idx); wr_data = d;
    step();
    idle();
  endtask

  task automatic ag_op(input logic [1:0] s, input logic [1:0] md, input logic [5:0] d);
    idle();
    ag_en = 1; ag_sel = s; ag_mode = md; ag_disp = d;
    step();
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    for (int i = 0; i < NREG; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all zero after reset
    for (int i = 0; i < NREG; i++) expect_reg("R1", i, 8'h00);

    // R2: byte write, old value visible in the writing cycle
    idle();
    wr_en = 1; wr_idx = 5'd5; wr_data = 16'h00A5; rd_b_idx = 5'd5;
    #1 chk("R2", rd_b_data, 8'h00);
    @(posedge clk); m[5] = 8'hA5; @(negedge clk);
    expect_reg("R2", 5, 8'hA5);

    // R4: pair write with odd index, R6: pointer X
    wr_w(27, 16'hBEEF);
    expect_reg("R4", 26, 8'hEF);
    expect_reg("R4", 27, 8'hBE);
    expect_ag("R6", 2'd0, 2'd0, 6'd0, 16'hBEEF);

    // R8: post-increment wraps
    wr_w(30, 16'hFFFF);
    ag_op(2'd2, 2'd1, 6'd0);
    expect_ag("R8", 2'd2, 2'd0, 6'd0, 16'h0000);

    // R9: pre-decrement wraps
    ag_op(2'd1, 2'd2, 6'd0);
    expect_ag("R9", 2'd1, 2'd0, 6'd0, 16'hFFFF);

    // R6: selector 3 aliases the third pointer
    wr_w(30, 16'h1234);
    expect_ag("R6", 2'd3, 2'd0, 6'd0, 16'h1234);

    // R10: displacement with carry, pointer untouched; ignored on X
    wr_w(28, 16'h00F0);
    expect_ag("R10", 2'd1, 2'd3, 6'd63, 16'h012F);
    ag_op(2'd1, 2'd3, 6'd63);
    expect_ag("R10", 2'd1, 2'd0, 6'd0, 16'h00F0);
    wr_w(26, 16'h4000);
    expect_ag("R10", 2'd0, 2'd3, 6'd63, 16'h4000);

    // R7: plain with enable leaves pointer
    ag_op(2'd1, 2'd0, 6'd0);
    expect_ag("R7", 2'd1, 2'd0, 6'd0, 16'h00F0);

    // R11: data-space hit and misses
    idle(); ds_en = 1; ds_we = 1; ds_addr = 16'h0003; ds_wdata = 8'h3C; step();
    expect_reg("R11", 3, 8'h3C);
    wr_b(0, 8'h5A);
    idle(); ds_en = 1; ds_we = 1; ds_addr = 16'h0020; ds_wdata = 8'hEE; step();
    expect_reg("R11", 0, 8'h5A);
    idle(); ds_en = 1; ds_we = 1; ds_addr = 16'h0100; ds_wdata = 8'hEE; step();
    expect_reg("R11", 0, 8'h5A);

    // R12: three writers on the third pointer
    wr_w(30, 16'h12FF);
    idle();
    wr_en = 1; wr_idx = 5'd30; wr_data = 16'h0011;
    ds_en = 1; ds_we = 1; ds_addr = 16'h001E; ds_wdata = 8'h22;
    ag_en = 1; ag_sel = 2'd2; ag_mode = 2'd1;
    step();
    expect_reg("R12", 30, 8'h11);
    expect_reg("R12", 31, 8'h13);
    idle();
    ds_en = 1; ds_we = 1; ds_addr = 16'h001F; ds_wdata = 8'h77;
    ag_en = 1; ag_sel = 2'd2; ag_mode = 2'd1;
    step();
    expect_reg("R12", 31, 8'h77);
    expect_reg("R12", 30, 8'h12);

    // constrained random mix biased to pointer registers
    for (int n = 0; n < 4000; n++) begin
      idle();
      rd_a_idx = ($urandom % 2) ? 5'(26 + $urandom % 6) : 5'($urandom);
      rd_b_idx = 5'($urandom);
      rd_w_idx = ($urandom % 2) ? 5'(26 + $urandom % 6) : 5'($urandom);
      wr_en    = ($urandom % 3) == 0;
      wr_wide  = $urandom % 2;
      wr_idx   = ($urandom % 2) ? 5'(26 + $urandom % 6) : 5'($urandom);
      wr_data  = 16'($urandom);
      ag_en    = ($urandom % 2) == 0;
      ag_sel   = 2'($urandom);
      ag_mode  = 2'($urandom);
      ag_disp  = 6'($urandom);
      ds_en    = ($urandom % 3) == 0;
      ds_we    = $urandom % 2;
      case ($urandom % 4)
        0:       ds_addr = 16'(26 + $urandom % 6);
        1:       ds_addr = 16'($urandom % 64);
        2:       ds_addr = 16'($urandom);
        default: ds_addr = 16'($urandom % 32);
      endcase
      ds_wdata = 8'($urandom);
      step();
    end

    idle();
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule